// File: doc/BRIEF.md
# Transmit FIFO with Free-Space Interrupt

This block is the transmit-side byte queue of a serial channel. The host writes bytes one at a time with a strobe. The serializer drains them in write order through a ready/pop interface, and the head byte is visible whenever the queue holds data. The queue runs at one of two depths, a small depth of 8 or a large depth of 256, chosen by a select input. Changing that select empties the queue.

The block raises a transmitter interrupt when enough of the queue is free. A two-bit level code picks the amount of free space that is enough:
- code 00: the whole queue is free;
- code 11: any single free position is enough;
- code 01: half the depth is free;
- code 10: three quarters of the depth is free.

The free-space count is also an output. The interrupt is held low while the transmitter is disabled. When the transmitter is enabled, the interrupt follows the condition in the same cycle.

A host write that arrives while the queue is full is dropped. It sets a sticky overrun flag, which clears only on reset or on a depth change.

Top module: `txf_top`

## Requirements
- R1: After reset, with deep_sel low, the queue is empty: free_cnt is 8 and full, rd_ready and overrun are 0. tx_irq is 0 while tx_en is 0.
- R2: Bytes leave on rd_data in the order they were accepted. rd_ready is 1 exactly when the queue holds at least one byte, and rd_data then shows the oldest byte.
- R3: free_cnt equals the active depth minus the number of stored bytes, and it changes at the clock edge that accepts a push or pop. A push and a pop accepted at the same edge leave it unchanged.
- R4: At depth 8 (deep_sel=0), with tx_en high, tx_irq is 1 when free_cnt is at least the following value, by level code: 8 for 00, 4 for 01, 6 for 10, 1 for 11.
- R5: At depth 256 (deep_sel=1), with tx_en high, tx_irq is 1 when free_cnt is at least the following value, by level code: 256 for 00, 128 for 01, 192 for 10, 1 for 11.
- R6: tx_irq is 0 whenever tx_en is 0. When tx_en rises and the level condition holds, tx_irq is 1 in the same cycle, with no clock edge in between.
- R7: A write while full is dropped, even if a pop is accepted at the same edge. It sets overrun, which stays 1 until reset or a depth change.
- R8: A pop while the queue is empty is ignored: free_cnt and rd_ready do not change.
- R9: At the first edge where deep_sel differs from the active depth, the queue is flushed. After that edge, free_cnt equals the new depth, and rd_ready and overrun are 0. Writes and pops in that cycle are ignored.
- R10: full is 1 exactly when free_cnt is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| deep_sel | input | 1 | 0 selects depth 8, 1 selects depth 256 |
| lvl_code | input | 2 | Free-space interrupt level code |
| tx_en | input | 1 | Transmitter enable; gates tx_irq |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| rd_pop | input | 1 | Serializer takes the head byte |
| rd_ready | output | 1 | Queue holds at least one byte |
| rd_data | output | 8 | Oldest stored byte |
| tx_irq | output | 1 | Transmitter interrupt |
| free_cnt | output | 9 | Number of free positions |
| full | output | 1 | No free position |
| overrun | output | 1 | Sticky flag for a dropped write |

## Verification
The bench sweeps all four level codes at every fill level of both depths. A design that followed the natural code order, rather than the half and three-quarter mapping, would therefore miss at the 4/6 and 128/192 boundaries.

It also covers three other cases. The first is a write into a full queue paired with a pop. A design that let the write through would lose the oldest byte or corrupt the order seen by the scoreboard. The second is a pop on an empty queue, which a careless counter would wrap to a huge free count. The third is a depth switch with data still stored. Without the flush, stale bytes would appear at the head, or the free count would not match the new depth.

// File: rtl/txf_pkg.sv
package txf_pkg;

  typedef enum logic [1:0] {
    LVL_ALL  = 2'b00,
    LVL_HALF = 2'b01,
    LVL_3Q   = 2'b10,
    LVL_ANY  = 2'b11
  } lvl_code_e;

  // Free positions needed before the interrupt may assert.
  function automatic int unsigned need_free(input int unsigned depth,
                                            input logic [1:0] code);
    case (lvl_code_e'(code))
      LVL_ALL:  return depth;
      LVL_HALF: return depth >> 1;
      LVL_3Q:   return (depth >> 1) + (depth >> 2);
      default:  return 1;
    endcase
  endfunction

  // Pointer step with wrap at the active depth.
  function automatic int unsigned ptr_step(input int unsigned ptr,
                                           input int unsigned depth);
    return (ptr + 1 == depth) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/txf_ctrl.sv
module txf_ctrl #(
  parameter int SMALL_DEPTH = 8,
  parameter int LARGE_DEPTH = 256,
  localparam int AW = $clog2(LARGE_DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          deep_sel,
  input  logic          wr_en,
  input  logic          rd_pop,
  output logic          flush_evt,
  output logic          push_acc,
  output logic          pop_acc,
  output logic          wr_drop,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] depth_now,
  output logic [CW-1:0] free_cnt,
  output logic          full,
  output logic          empty,
  output logic          overrun
);
  localparam logic [CW-1:0] DEP_S = CW'(SMALL_DEPTH);
  localparam logic [CW-1:0] DEP_L = CW'(LARGE_DEPTH);

  logic          deep_q;
  logic [CW-1:0] occ;
  logic          ovr_q;

  assign depth_now = deep_q ? DEP_L : DEP_S;
  assign flush_evt = deep_sel != deep_q;
  assign empty     = occ == '0;
  assign full      = occ == depth_now;
  assign free_cnt  = depth_now - occ;
  assign overrun   = ovr_q;

  assign push_acc  = wr_en  && !full  && !flush_evt;
  assign pop_acc   = rd_pop && !empty && !flush_evt;
  assign wr_drop   = wr_en  &&  full  && !flush_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      deep_q <= 1'b0;
      occ    <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      ovr_q  <= 1'b0;
    end else if (flush_evt) begin
      deep_q <= deep_sel;
      occ    <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      ovr_q  <= 1'b0;
    end else begin
      occ <= occ + CW'(push_acc) - CW'(pop_acc);
      if (push_acc)
        wr_ptr <= AW'(txf_pkg::ptr_step(32'(wr_ptr), 32'(depth_now)));
      if (pop_acc)
        rd_ptr <= AW'(txf_pkg::ptr_step(32'(rd_ptr), 32'(depth_now)));
      if (wr_drop)
        ovr_q <= 1'b1;
    end
  end
endmodule

// File: rtl/txf_mem.sv
module txf_mem #(
  parameter int ENTRIES = 256,
  parameter int DATA_W  = 8,
  localparam int AW = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/txf_thresh.sv
module txf_thresh #(
  parameter int CW = 9
) (
  input  logic [CW-1:0] free_cnt,
  input  logic [CW-1:0] depth_now,
  input  logic [1:0]    lvl_code,
  input  logic          tx_en,
  output logic          tx_irq
);
  logic [CW-1:0] need [4];
  logic [3:0]    hit;

  for (genvar c = 0; c < 4; c++) begin : g_lvl
    assign need[c] = CW'(txf_pkg::need_free(32'(depth_now), 2'(c)));
    assign hit[c]  = free_cnt >= need[c];
  end

  assign tx_irq = tx_en && hit[lvl_code];
endmodule

// File: rtl/txf_top.sv
module txf_top #(
  parameter int SMALL_DEPTH = 8,
  parameter int LARGE_DEPTH = 256,
  parameter int DATA_W      = 8,
  localparam int AW = $clog2(LARGE_DEPTH),
  localparam int CW = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deep_sel,
  input  logic [1:0]        lvl_code,
  input  logic              tx_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_pop,
  output logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              tx_irq,
  output logic [CW-1:0]     free_cnt,
  output logic              full,
  output logic              overrun
);
  logic          flush_evt;
  logic          push_acc;
  logic          pop_acc;
  logic          wr_drop;
  logic          empty;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] depth_now;

  txf_ctrl #(.SMALL_DEPTH(SMALL_DEPTH), .LARGE_DEPTH(LARGE_DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .deep_sel(deep_sel), .wr_en(wr_en),
    .rd_pop(rd_pop), .flush_evt(flush_evt), .push_acc(push_acc),
    .pop_acc(pop_acc), .wr_drop(wr_drop), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .depth_now(depth_now), .free_cnt(free_cnt), .full(full),
    .empty(empty), .overrun(overrun)
  );

  txf_mem #(.ENTRIES(LARGE_DEPTH), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(push_acc), .waddr(wr_ptr), .wdata(wr_data),
    .raddr(rd_ptr), .rdata(rd_data)
  );

  txf_thresh #(.CW(CW)) u_thr (
    .free_cnt(free_cnt), .depth_now(depth_now), .lvl_code(lvl_code),
    .tx_en(tx_en), .tx_irq(tx_irq)
  );

  assign rd_ready = !empty;
endmodule

// File: rtl/txf_chk.sv
module txf_chk #(
  parameter int CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_pop,
  input logic          tx_en,
  input logic [1:0]    lvl_code,
  input logic          tx_irq,
  input logic [CW-1:0] free_cnt,
  input logic [CW-1:0] depth_now,
  input logic          full,
  input logic          overrun,
  input logic          rd_ready,
  input logic          flush_evt,
  input logic          push_acc,
  input logic          pop_acc
);
  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= depth_now); // R3
  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    push_acc && pop_acc |=> $stable(free_cnt)); // R3
  AST_ANY_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en && lvl_code == 2'b11 && !full |-> tx_irq); // R4
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !tx_irq); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_en && !rd_pop && !flush_evt |=> full && overrun); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !flush_evt |=> overrun); // R7
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ready && rd_pop && !wr_en && !flush_evt |=> !rd_ready && !pop_acc); // R8
  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |=> !rd_ready && !overrun && free_cnt == depth_now); // R9
endmodule

bind txf_top txf_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_pop(rd_pop), .tx_en(tx_en),
  .lvl_code(lvl_code), .tx_irq(tx_irq), .free_cnt(free_cnt),
  .depth_now(depth_now), .full(full), .overrun(overrun),
  .rd_ready(rd_ready), .flush_evt(flush_evt), .push_acc(push_acc),
  .pop_acc(pop_acc)
);

// File: tb/sim_txf_top.sv
`timescale 1ns/100ps
module sim_txf_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       deep_sel = 0;
  logic [1:0] lvl_code = 0;
  logic       tx_en = 0;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0;
  logic       rd_pop = 0;
  logic       rd_ready;
  logic [7:0] rd_data;
  logic       tx_irq;
  logic [8:0] free_cnt;
  logic       full;
  logic       overrun;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;
  int  dep     = 8;
  int  occ     = 0;
  bit  m_ovr   = 0;
  logic [7:0] sq [$];

  always #2.5 clk = ~clk;

  txf_top u0 (
    .clk(clk), .rst_n(rst_n), .deep_sel(deep_sel), .lvl_code(lvl_code),
    .tx_en(tx_en), .wr_en(wr_en), .wr_data(wr_data), .rd_pop(rd_pop),
    .rd_ready(rd_ready), .rd_data(rd_data), .tx_irq(tx_irq),
    .free_cnt(free_cnt), .full(full), .overrun(overrun)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_irq(int d, int code, int fr, bit en);
    int need;
    case (code)
      0: need = d;
      1: need = d / 2;
      2: need = (d * 3) / 4;
      default: need = 1;
    endcase
    return en && (fr >= need);
  endfunction

  // Monitor: compare the byte taken by the serializer with the scoreboard.
  always @(negedge clk) begin
    if (rst_n && rd_pop && rd_ready) begin
      if (sq.size() == 0) chk("R2", "pop with empty scoreboard", 1, 0);
      else chk("R2", "head byte", int'(rd_data), int'(sq.pop_front()));
    end
  end

  // Driver: one clock of stimulus, model updated from the requirements.
  task automatic cyc(bit w, logic [7:0] d, bit p);
    bit push_ok = w && occ < dep;
    bit pop_ok  = p && occ > 0;
    wr_en = w; wr_data = d; rd_pop = p;
    if (w && occ >= dep) m_ovr = 1;
    if (push_ok) sq.push_back(d);
    @(posedge clk); #1;
    occ = occ + int'(push_ok) - int'(pop_ok);
    wr_en = 0; rd_pop = 0;
  endtask

  task automatic status(string tag);
    string lv = (dep == 8) ? "R4" : "R5";
    chk("R3", {tag, " free_cnt"}, int'(free_cnt), dep - occ);
    chk("R10", {tag, " full"}, int'(full), int'(occ == dep));
    chk("R2", {tag, " rd_ready"}, int'(rd_ready), int'(occ > 0));
    chk("R7", {tag, " overrun"}, int'(overrun), int'(m_ovr));
    for (int c = 0; c < 4; c++) begin
      lvl_code = 2'(c);
      #0.1;
      chk(lv, {tag, " tx_irq"}, int'(tx_irq), int'(exp_irq(dep, c, dep - occ, tx_en)));
    end
    lvl_code = 0;
  endtask

  task automatic set_depth(bit s);
    deep_sel = s;
    @(posedge clk); #1;
    dep = s ? 256 : 8; occ = 0; m_ovr = 0; sq.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state
    chk("R1", "free_cnt", int'(free_cnt), 8);
    chk("R1", "full", int'(full), 0);
    chk("R1", "rd_ready", int'(rd_ready), 0);
    chk("R1", "overrun", int'(overrun), 0);
    chk("R1", "tx_irq", int'(tx_irq), 0);
    // R6: enable raises irq in the same cycle (code 00, all free)
    tx_en = 1; #0.5;
    chk("R6", "irq on enable", int'(tx_irq), 1);
    // R4: one byte withdraws code 00 request; sweep all fill levels
    for (int i = 0; i <= 8; i++) begin
      status("fill8");
      cyc(1, 8'(8'h30 + i), 0);
    end
    status("full8");
    chk("R7", "overrun after full write", int'(overrun), 1);
    // R6: disable forces irq low
    tx_en = 0; status("dis"); tx_en = 1;
    // R7 with pop: write dropped, pop accepted
    cyc(1, 8'hEE, 1); status("fullpair");
    // R3: push and pop together keep free_cnt
    cyc(1, 8'h77, 1); status("pair");
    while (occ > 0) begin cyc(0, 0, 1); status("drain8"); end
    // R8: pop on empty ignored
    cyc(0, 0, 1); status("emptypop");
    chk("R8", "free after empty pop", int'(free_cnt), 8);
    cyc(1, 8'hA1, 1); status("emptypair");
    cyc(0, 0, 1); status("drain1");
    // R9: switch to large depth flushes
    cyc(1, 8'h11, 0); cyc(1, 8'h12, 0);
    set_depth(1);
    chk("R9", "free after flush", int'(free_cnt), 256);
    chk("R9", "ready after flush", int'(rd_ready), 0);
    chk("R9", "overrun after flush", int'(overrun), 0);
    // R5: sweep large depth
    for (int i = 0; i <= 256; i++) begin
      status("fill256");
      cyc(1, 8'(i * 7 + 3), 0);
    end
    status("full256");
    while (occ > 0) begin cyc(0, 0, 1); if (occ % 32 == 0) status("drain256"); end
    cyc(1, 8'h21, 0); cyc(1, 8'h22, 0); cyc(1, 8'h23, 0);
    set_depth(0);
    chk("R9", "free after flush back", int'(free_cnt), 8);
    chk("R9", "ready after flush back", int'(rd_ready), 0);
    cyc(1, 8'h5A, 0);
    cyc(0, 0, 1); status("post flush");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule